// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup stage of a direct-mapped data cache. The set is chosen from untranslated page-offset bits of the request, so the tag and data arrays are read in the same cycle that an external translation unit produces the physical frame number. The frame number arrives alongside the request with a translation-valid flag. It is compared against the physical tag stored in the selected line.

A request is accepted only while a valid translation is present and no miss is outstanding. An accepted request reports a hit, with the selected 32-bit word, or a miss one cycle later. A miss issues a line fill request carrying the physical line address. The fill response installs the tag, the valid bit and the line data. The requester then presents the access again. A flush input invalidates every line in a single cycle.

Streams follow valid/ready rules. A request transfers on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low whenever translation is absent or a miss is outstanding. The fill request holds its valid and address until `fill_req_ready` accepts it. The fill response transfers when `fill_rsp_valid` meets `fill_rsp_ready`, which is high only while the block waits for that data.

Top module: `vipt_lookup`

## Requirements
- R1: The line index is `req_voff[9:4]` (64 lines) and the word within the 64-byte line is `req_voff[3:0]`; word w of a line occupies bits [32w+31:32w] of the fill data.
- R2: An accepted request whose line is valid and whose stored tag equals `req_pfn` raises `hit_o` for exactly one cycle, one cycle after acceptance, with `rdata_o` holding the selected word; `hit_o` and `miss_o` are never high together.
- R3: While `tlb_hit` is low, `req_ready` is low, no hit or miss is reported, and cache contents are unchanged.
- R4: An accepted request that does not hit raises `miss_o` for one cycle, one cycle after acceptance; in that same cycle `fill_req_valid` rises with `fill_req_addr` = {pfn, index}, and both hold steady until `fill_req_ready` is seen.
- R5: From the miss until the fill response is taken, `req_ready` stays low.
- R6: A fill response writes the line's tag and data and sets its valid bit, so the repeated request hits and returns the filled word.
- R7: Two virtual addresses that share a page offset and translate to the same frame select and hit the same line.
- R8: A flush invalidates every line; when a flush coincides with a fill response, the flush wins and the line stays invalid.
- R9: A lookup accepted in the same cycle as a flush sees the contents from before the flush.
- R10: After reset all lines are invalid, `hit_o`, `miss_o`, `fill_req_valid` and `fill_rsp_ready` are low, and `req_ready` follows `tlb_hit`.
- R11: A request to a valid line with a different stored frame misses, and its fill replaces the old line, so the earlier frame then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_voff | input | 10 | Word-granular page offset of the virtual address |
| tlb_hit | input | 1 | Translation for this request is valid |
| req_pfn | input | 20 | Physical frame number from translation |
| flush | input | 1 | Invalidate all lines |
| hit_o | output | 1 | Hit result pulse |
| miss_o | output | 1 | Miss result pulse |
| rdata_o | output | 32 | Word read on a hit |
| fill_req_valid | output | 1 | Line fill request valid |
| fill_req_ready | input | 1 | Line fill request accepted |
| fill_req_addr | output | 26 | Physical line address of the fill |
| fill_rsp_valid | input | 1 | Fill data valid |
| fill_rsp_ready | output | 1 | Block waits for fill data |
| fill_rsp_data | input | 512 | Full line of fill data |

## Verification
A corrupted valid bit or tag shows up as a wrong hit or miss on the very next access to that line, one cycle after acceptance, because each result is checked against an independent model of every line. A corrupted word in the data array surfaces as a wrong `rdata_o` on the first hit to that word. A miss controller stuck in the wrong phase shows up at once as a `req_ready` or `fill_rsp_ready` value that disagrees with the handshake the bench is driving.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Phases of an outstanding line fill
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ASK  = 2'd1,
    MS_WAIT = 2'd2
  } miss_state_t;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             flush
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // Flush dominates any install in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (flush)  vld_q <= '0;
    else if (wr_en)  vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32,
  parameter int WORDS  = 16
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORDS*WORD_W-1:0] wr_line,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  output logic [WORD_W-1:0]       rd_data
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = WORDS * WORD_W;
  localparam int WSEL_W = $clog2(WORDS);

  logic [LINE_W-1:0] mem_q [LINES];
  logic [LINE_W-1:0] sel_line;
  logic [WORD_W-1:0] word_slot [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end

  assign sel_line = mem_q[rd_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_slot
    assign word_slot[w] = sel_line[w*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_word == WSEL_W'(w)) rd_data = word_slot[w];
    end
  end
endmodule

// File: rtl/vipt_miss_fsm.sv
module vipt_miss_fsm
  import vipt_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [TAG_W-1:0]       start_tag,
  input  logic [IDX_W-1:0]       start_idx,
  output logic                   idle,
  output logic                   fill_req_valid,
  input  logic                   fill_req_ready,
  output logic [TAG_W+IDX_W-1:0] fill_req_addr,
  input  logic                   fill_rsp_valid,
  output logic                   fill_rsp_ready,
  output logic                   install_en,
  output logic [IDX_W-1:0]       install_idx,
  output logic [TAG_W-1:0]       install_tag
);
  miss_state_t      st_q, st_d;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MS_IDLE: if (start)          st_d = MS_ASK;
      MS_ASK:  if (fill_req_ready) st_d = MS_WAIT;
      MS_WAIT: if (fill_rsp_valid) st_d = MS_IDLE;
      default:                     st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      tag_q <= '0;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == MS_IDLE && start) begin
        tag_q <= start_tag;
        idx_q <= start_idx;
      end
    end
  end

  assign idle           = (st_q == MS_IDLE);
  assign fill_req_valid = (st_q == MS_ASK);
  assign fill_req_addr  = {tag_q, idx_q};
  assign fill_rsp_ready = (st_q == MS_WAIT);
  assign install_en     = (st_q == MS_WAIT) && fill_rsp_valid;
  assign install_idx    = idx_q;
  assign install_tag    = tag_q;
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int PA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int IDX_W      = 6,
  parameter int LINE_OFF_W = 6,
  parameter int WORD_W     = 32,
  localparam int TAG_W     = PA_W - PAGE_OFF_W,
  localparam int WORDS     = ((1 << LINE_OFF_W) * 8) / WORD_W,
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int BSEL_W    = $clog2(WORD_W / 8),
  localparam int VOFF_W    = IDX_W + LINE_OFF_W - BSEL_W,
  localparam int LINE_W    = WORDS * WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VOFF_W-1:0]      req_voff,
  input  logic                   tlb_hit,
  input  logic [TAG_W-1:0]       req_pfn,
  input  logic                   flush,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic [WORD_W-1:0]      rdata_o,
  output logic                   fill_req_valid,
  input  logic                   fill_req_ready,
  output logic [TAG_W+IDX_W-1:0] fill_req_addr,
  input  logic                   fill_rsp_valid,
  output logic                   fill_rsp_ready,
  input  logic [LINE_W-1:0]      fill_rsp_data
);
  // Index plus line offset must lie inside the page offset (index is untranslated)
  logic [IDX_W-1:0]  look_idx;
  logic [WSEL_W-1:0] look_word;
  logic              line_vld;
  logic [TAG_W-1:0]  line_tag;
  logic [WORD_W-1:0] line_word;
  logic              tag_match;
  logic              fire;
  logic              idle;
  logic              inst_en;
  logic [IDX_W-1:0]  inst_idx;
  logic [TAG_W-1:0]  inst_tag;

  assign look_idx  = req_voff[VOFF_W-1 -: IDX_W];
  assign look_word = req_voff[WSEL_W-1:0];

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_valid (line_vld),
    .rd_tag   (line_tag),
    .wr_en    (inst_en),
    .wr_idx   (inst_idx),
    .wr_tag   (inst_tag),
    .flush    (flush)
  );

  vipt_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .wr_en   (inst_en),
    .wr_idx  (inst_idx),
    .wr_line (fill_rsp_data),
    .rd_idx  (look_idx),
    .rd_word (look_word),
    .rd_data (line_word)
  );

  // Physical compare of the virtually indexed line
  assign tag_match = line_vld && (line_tag == req_pfn);
  assign req_ready = idle && tlb_hit;
  assign fire      = req_valid && req_ready;

  vipt_miss_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_miss (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (fire && !tag_match),
    .start_tag      (req_pfn),
    .start_idx      (look_idx),
    .idle           (idle),
    .fill_req_valid (fill_req_valid),
    .fill_req_ready (fill_req_ready),
    .fill_req_addr  (fill_req_addr),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_ready (fill_rsp_ready),
    .install_en     (inst_en),
    .install_idx    (inst_idx),
    .install_tag    (inst_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      hit_o  <= fire && tag_match;
      miss_o <= fire && !tag_match;
      if (fire && tag_match) rdata_o <= line_word;
    end
  end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   tlb_hit,
  input logic                   flush,
  input logic                   hit_o,
  input logic                   miss_o,
  input logic                   fill_req_valid,
  input logic                   fill_req_ready,
  input logic [TAG_W+IDX_W-1:0] fill_req_addr,
  input logic                   fill_rsp_ready
);
  assert_hit_needs_xlat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(req_valid && tlb_hit));

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  assert_miss_asks_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> fill_req_valid);

  assert_fill_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  assert_fill_phases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_req_valid && fill_rsp_ready));

  assert_stall_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid || fill_rsp_ready) |-> !req_ready);

  assert_flush_kills_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && req_valid && req_ready) |=> !hit_o);
endmodule

bind vipt_lookup vipt_lookup_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_vipt_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .tlb_hit        (tlb_hit),
  .flush          (flush),
  .hit_o          (hit_o),
  .miss_o         (miss_o),
  .fill_req_valid (fill_req_valid),
  .fill_req_ready (fill_req_ready),
  .fill_req_addr  (fill_req_addr),
  .fill_rsp_ready (fill_rsp_ready)
);

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W  = 20;
  localparam int IDX_W  = 6;
  localparam int WORDS  = 16;
  localparam int WORD_W = 32;
  localparam int LINES  = 64;
  localparam int LINE_W = WORDS * WORD_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, tlb_hit = 0, flush = 0;
  logic [9:0] req_voff = '0;
  logic [TAG_W-1:0] req_pfn = '0;
  logic req_ready, hit_o, miss_o, fill_req_valid, fill_rsp_ready;
  logic [WORD_W-1:0] rdata_o;
  logic fill_req_ready = 0, fill_rsp_valid = 0;
  logic [TAG_W+IDX_W-1:0] fill_req_addr;
  logic [LINE_W-1:0] fill_rsp_data = '0;

  vipt_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_voff(req_voff), .tlb_hit(tlb_hit), .req_pfn(req_pfn), .flush(flush),
    .hit_o(hit_o), .miss_o(miss_o), .rdata_o(rdata_o),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_rsp_valid(fill_rsp_valid),
    .fill_rsp_ready(fill_rsp_ready), .fill_rsp_data(fill_rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  bit               m_vld [LINES];
  logic [TAG_W-1:0] m_tag [LINES];
  logic [WORD_W-1:0] m_dat [LINES][WORDS];
  int n_chk = 0, n_fail = 0, salt = 0;
  logic [TAG_W-1:0] pfn_pool [4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] fill_word(input logic [TAG_W+IDX_W-1:0] la,
                                                  input int w, input int s);
    return (32'(la) * 32'h9E3779B1) ^ (32'(w) * 32'h01000193) ^ (32'(s) << 20);
  endfunction

  // One lookup; on a miss the fill is served. with_flush: flush rides on the
  // request cycle. flush_fill: flush coincides with the fill response.
  task automatic lookup(input logic [IDX_W-1:0] idx, input logic [3:0] w,
                        input logic [TAG_W-1:0] pfn, input bit tlb,
                        input bit with_flush, input bit flush_fill,
                        input string rq, output bit got_hit);
    bit exp_hit;
    logic [TAG_W+IDX_W-1:0] la;
    @(negedge clk);
    req_valid = 1; req_voff = {idx, w}; req_pfn = pfn; tlb_hit = tlb; flush = with_flush;
    #1;
    chk(req_ready === tlb, "R3", "req_ready", req_ready, tlb);
    exp_hit = tlb && m_vld[idx] && (m_tag[idx] == pfn);
    @(negedge clk);
    req_valid = 0; tlb_hit = 0; flush = 0;
    if (with_flush) for (int i = 0; i < LINES; i++) m_vld[i] = 0;
    chk(hit_o === exp_hit, rq, "hit_o", hit_o, exp_hit);
    chk(miss_o === (tlb && !exp_hit), rq, "miss_o", miss_o, tlb && !exp_hit);
    if (exp_hit)
      chk(rdata_o === m_dat[idx][w], "R1", "rdata_o", rdata_o, m_dat[idx][w]);
    got_hit = exp_hit;
    if (tlb && !exp_hit) begin
      la = {pfn, idx};
      chk(fill_req_valid === 1'b1 && fill_req_addr === la, "R4", "fill_req_addr", fill_req_addr, la);
      tlb_hit = 1; #1;
      chk(req_ready === 1'b0, "R5", "req_ready during miss", req_ready, 0);
      tlb_hit = 0;
      for (int d = $urandom_range(0, 3); d > 0; d--) begin
        @(negedge clk);
        chk(fill_req_valid === 1'b1 && fill_req_addr === la, "R4", "held fill_req", fill_req_addr, la);
      end
      fill_req_ready = 1;
      @(negedge clk);
      fill_req_ready = 0;
      chk(fill_req_valid === 1'b0 && fill_rsp_ready === 1'b1, "R4", "fill phase", fill_rsp_ready, 1);
      for (int d = $urandom_range(0, 2); d > 0; d--) begin
        @(negedge clk);
        tlb_hit = 1; #1;
        chk(fill_rsp_ready === 1'b1 && req_ready === 1'b0, "R5", "wait phase", req_ready, 0);
        tlb_hit = 0;
      end
      salt++;
      for (int k = 0; k < WORDS; k++) fill_rsp_data[k*WORD_W +: WORD_W] = fill_word(la, k, salt);
      fill_rsp_valid = 1; flush = flush_fill;
      @(negedge clk);
      fill_rsp_valid = 0; flush = 0;
      if (flush_fill) for (int i = 0; i < LINES; i++) m_vld[i] = 0;
      else begin
        m_vld[idx] = 1; m_tag[idx] = pfn;
        for (int k = 0; k < WORDS; k++) m_dat[idx][k] = fill_word(la, k, salt);
      end
      chk(fill_rsp_ready === 1'b0, "R6", "fill done", fill_rsp_ready, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < LINES; i++) m_vld[i] = 0;
    pfn_pool[0] = 20'h12345; pfn_pool[1] = 20'hABCDE;
    pfn_pool[2] = 20'h00001; pfn_pool[3] = 20'hFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hit_o === 0 && miss_o === 0, "R10", "result pulses", {hit_o, miss_o}, 0);
    chk(fill_req_valid === 0 && fill_rsp_ready === 0, "R10", "fill idle", {fill_req_valid, fill_rsp_ready}, 0);
    chk(req_ready === 0, "R10", "ready w/o xlat", req_ready, 0);
    tlb_hit = 1; #1;
    chk(req_ready === 1, "R10", "ready with xlat", req_ready, 1);
    tlb_hit = 0;

    // Miss, fill, replay hits (R6); same line other word (R1)
    lookup(6'd5, 4'd3, pfn_pool[0], 1, 0, 0, "R4", h);
    lookup(6'd5, 4'd3, pfn_pool[0], 1, 0, 0, "R6", h);
    chk(h, "R6", "replay hit", h, 1);
    lookup(6'd5, 4'd15, pfn_pool[0], 1, 0, 0, "R1", h);
    // Translation absent: no result, line untouched (R3)
    lookup(6'd5, 4'd3, pfn_pool[0], 0, 0, 0, "R3", h);
    chk(hit_o === 0 && miss_o === 0, "R3", "no result", {hit_o, miss_o}, 0);
    // Alias: another virtual page, same offset, same frame (R7)
    lookup(6'd5, 4'd3, pfn_pool[0], 1, 0, 0, "R7", h);
    chk(h, "R7", "alias hits", h, 1);
    // Conflict replaces (R11)
    lookup(6'd5, 4'd0, pfn_pool[1], 1, 0, 0, "R11", h);
    lookup(6'd5, 4'd0, pfn_pool[0], 1, 0, 0, "R11", h);
    chk(!h, "R11", "old frame misses", h, 0);
    // Lookup in flush cycle sees old contents (R9), then all miss (R8)
    lookup(6'd5, 4'd2, pfn_pool[0], 1, 1, 0, "R9", h);
    chk(h, "R9", "pre-flush hit", h, 1);
    lookup(6'd5, 4'd2, pfn_pool[0], 1, 0, 0, "R8", h);
    chk(!h, "R8", "post-flush miss", h, 0);
    // Flush concurrent with fill response wins (R8)
    lookup(6'd9, 4'd1, pfn_pool[2], 1, 0, 1, "R8", h);
    lookup(6'd9, 4'd1, pfn_pool[2], 1, 0, 0, "R8", h);
    chk(!h, "R8", "flush beat fill", h, 0);
    lookup(6'd63, 4'd15, pfn_pool[3], 1, 0, 0, "R4", h);
    lookup(6'd63, 4'd15, pfn_pool[3], 1, 0, 0, "R6", h);
    chk(h, "R6", "top line hit", h, 1);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      lookup(IDX_W'($urandom_range(0, 7) * 9), 4'($urandom_range(0, 15)),
             pfn_pool[$urandom_range(0, 3)], ($urandom_range(0, 99) < 85),
             ($urandom_range(0, 99) < 3), ($urandom_range(0, 99) < 3), "R2", h);
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule